// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block runs the parallel programming mode of a 4 KB on-chip code flash. An external programmer presents an address, a data byte and a mode code, applies high voltage and strobes an active-low program pulse. The sequencer turns that pulse into a timed byte write, a chip erase or a lock-bit write. It drives the write and erase controls of the flash array and returns read data for verify and signature reads.

A byte write runs by itself for `WRITE_CYCLES` clocks and reports progress in two ways. The `ready` output goes low for the whole write. A verify read of the address being written returns the inverted bit 7 of the new data. A chip erase happens only when the pulse stays low for `ERASE_HOLD_CYCLES` clocks. In this model the array lives outside the block and is read asynchronously through `arr_addr`/`arr_rdata`.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset `ready` is 1, `dout` is FFH, and `arr_we` and `arr_erase` are 0.
- R2: A falling edge of `prog_n` in mode 1 (byte write) with `hv_ok` high and the block idle drives `ready` low from the next clock for exactly `WRITE_CYCLES` cycles. The write gives a single `arr_we` pulse, and the written byte lands in the array.
- R3: While a byte write is in progress, a verify read (mode 2) of its address returns the complement of bit 7 of the written data on `dout[7]`. After completion the verify read returns the true byte.
- R4: A falling edge of `prog_n` in mode 3 (chip erase) with `hv_ok` high, held low for `ERASE_HOLD_CYCLES` cycles, gives one `arr_erase` pulse. The array then reads FFH everywhere and both lock bits are cleared.
- R5: If `prog_n` is released before `ERASE_HOLD_CYCLES`, the erase is aborted: there is no `arr_erase` pulse and the array keeps its contents.
- R6: A byte write can only clear bits: the stored value becomes old AND new data.
- R7: A program pulse that arrives while a write is busy is ignored.
- R8: A program pulse with `hv_ok` low is ignored.
- R9: Once lock bit 1 has been programmed (mode 5, timed like a byte write), byte-write pulses are ignored. Lock bit 2 is programmed with mode 6.
- R10: While either lock bit is set, verify reads return FFH.
- R11: Signature reads (mode 4) return 1EH at 030H and 51H at 031H. At 032H they return FFH when `HV12_PART` is 1 and 05H otherwise. Every other address returns FFH.
- R12: `dout` is registered, with one cycle from mode/address to data. In mode 0 and in any other non-read mode it reads FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 12 | Byte address |
| din | input | 8 | Data byte to program |
| mode | input | 3 | 0 none, 1 write, 2 verify, 3 erase, 4 signature, 5 lock1, 6 lock2 |
| hv_ok | input | 1 | Programming voltage present |
| prog_n | input | 1 | Active-low program pulse |
| dout | output | 8 | Read data |
| ready | output | 1 | 1 ready, 0 busy writing |
| arr_addr | output | 12 | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_we | output | 1 | Array byte write strobe |
| arr_erase | output | 1 | Array bulk erase strobe |
| arr_rdata | input | 8 | Array read data at `arr_addr` |

## Verification
The assertions check these on every cycle: the exact busy length of each write, that busy only starts after a high-to-low pulse transition, that write and erase strobes never coincide, and that erase happens only while the pulse is held and outside a write. Array contents, AND-only writes, data polling, lock effects, aborted erases and signature values depend on what was written earlier. Only the bench's scenarios, with a model array that is read back, can show them.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int ADDR_W            = 12,
  parameter int WRITE_CYCLES      = 16,
  parameter int ERASE_HOLD_CYCLES = 64,
  parameter bit HV12_PART         = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [2:0]        mode,
  input  logic              hv_ok,
  input  logic              prog_n,
  output logic [7:0]        dout,
  output logic              ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              arr_we,
  output logic              arr_erase,
  input  logic [7:0]        arr_rdata
);
  localparam int MAXC = (WRITE_CYCLES > ERASE_HOLD_CYCLES) ? WRITE_CYCLES : ERASE_HOLD_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [2:0] M_WR = 3'd1, M_VER = 3'd2, M_ERA = 3'd3,
                         M_SIG = 3'd4, M_LK1 = 3'd5, M_LK2 = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_HOLD} st_t;

  st_t               state;
  logic [CW-1:0]     cnt;
  logic [2:0]        op;
  logic [ADDR_W-1:0] wa;
  logic [7:0]        wd;
  logic              lock1, lock2, prog_q;
  logic              start, wr_end;
  logic [7:0]        rd_next;

  assign start     = prog_q & ~prog_n & hv_ok & (state == S_IDLE);
  assign wr_end    = (state == S_WRITE) && (cnt == '0);
  assign arr_we    = wr_end && (op == M_WR);
  assign arr_erase = (state == S_HOLD) && (cnt == '0) && !prog_n;
  assign arr_addr  = wr_end ? wa : addr;
  assign arr_wdata = arr_rdata & wd;
  assign ready     = (state != S_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      op     <= '0;
      wa     <= '0;
      wd     <= '0;
      lock1  <= 1'b0;
      lock2  <= 1'b0;
      prog_q <= 1'b1;
    end else begin
      prog_q <= prog_n;
      case (state)
        S_IDLE:
          if (start) begin
            if ((mode == M_WR || mode == M_LK1 || mode == M_LK2) && !lock1) begin
              state <= S_WRITE;
              op    <= mode;
              wa    <= addr;
              wd    <= din;
              cnt   <= CW'(WRITE_CYCLES - 1);
            end else if (mode == M_ERA) begin
              state <= S_HOLD;
              cnt   <= CW'(ERASE_HOLD_CYCLES - 1);
            end
          end
        S_WRITE:
          if (cnt == '0) begin
            state <= S_IDLE;
            if (op == M_LK1) lock1 <= 1'b1;
            if (op == M_LK2) lock2 <= 1'b1;
          end else cnt <= cnt - 1'b1;
        S_HOLD:
          if (prog_n) state <= S_IDLE;
          else if (cnt == '0) begin
            state <= S_IDLE;
            lock1 <= 1'b0;
            lock2 <= 1'b0;
          end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_next = 8'hFF;
    if (mode == M_VER) begin
      if (state == S_WRITE && op == M_WR && addr == wa) rd_next = {~wd[7], wd[6:0]};
      else if (!(lock1 || lock2))                       rd_next = arr_rdata;
    end else if (mode == M_SIG) begin
      case (addr)
        ADDR_W'(12'h030): rd_next = 8'h1E;
        ADDR_W'(12'h031): rd_next = 8'h51;
        ADDR_W'(12'h032): rd_next = HV12_PART ? 8'hFF : 8'h05;
        default:          rd_next = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dout <= 8'hFF;
    else        dout <= rd_next;
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int WRITE_CYCLES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic prog_n,
  input logic ready,
  input logic arr_we,
  input logic arr_erase
);
  int busy_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      busy_cnt <= 0;
    else if (!ready) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;

  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> busy_cnt == WRITE_CYCLES);

  a_r2_busy_after_pulse_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> (!$past(prog_n) && $past(prog_n, 2)));

  a_r2_we_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (!ready ##1 ready));

  a_r4_erase_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase |-> (!prog_n && ready));

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_we && arr_erase));
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .ready(ready),
  .arr_we(arr_we), .arr_erase(arr_erase)
);

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;
  localparam int W = 16;
  localparam int H = 64;
  localparam logic [2:0] M_NONE = 3'd0, M_WR = 3'd1, M_VER = 3'd2, M_ERA = 3'd3,
                         M_SIG = 3'd4, M_LK1 = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  din = '0;
  logic [2:0]  mode = M_NONE;
  logic hv_ok = 1'b1, prog_n = 1'b1;
  logic [7:0]  dout, arr_wdata, arr_rdata;
  logic [11:0] arr_addr;
  logic ready, arr_we, arr_erase;
  logic [7:0] mem [4096];
  int total = 0, bad = 0, we_cnt = 0, er_cnt = 0;

  always #5 clk = ~clk;

  flash_prog_seq #(.WRITE_CYCLES(W), .ERASE_HOLD_CYCLES(H)) i_flash_prog_seq (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mode(mode), .hv_ok(hv_ok),
    .prog_n(prog_n), .dout(dout), .ready(ready), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_erase(arr_erase), .arr_rdata(arr_rdata));

  assign arr_rdata = mem[arr_addr];

  initial for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;

  always @(posedge clk) begin
    if (arr_erase) begin
      er_cnt <= er_cnt + 1;
      for (int i = 0; i < 4096; i++) mem[i] <= 8'hFF;
    end else if (arr_we) begin
      we_cnt <= we_cnt + 1;
      mem[arr_addr] <= arr_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [2:0] m, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); mode = m; addr = a; din = d; prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
  endtask

  task automatic rd(input logic [2:0] m, input logic [11:0] a, output logic [7:0] v);
    @(negedge clk); mode = m; addr = a;
    @(negedge clk); v = dout;
  endtask

  task automatic hold_erase(input int n);
    @(negedge clk); mode = M_ERA; prog_n = 1'b0;
    repeat (n) @(negedge clk);
    prog_n = 1'b1;
    @(negedge clk);
  endtask

  // {op, addr, data, expected}: op 0 write, 1 verify, 2 signature
  localparam logic [30:0] VEC [11] = '{
    {3'd0, 12'h005, 8'hA5, 8'h00}, {3'd1, 12'h005, 8'h00, 8'hA5},
    {3'd0, 12'h005, 8'h3C, 8'h00}, {3'd1, 12'h005, 8'h00, 8'h24},
    {3'd0, 12'hFFF, 8'h00, 8'h00}, {3'd1, 12'hFFF, 8'h00, 8'h00},
    {3'd1, 12'h100, 8'h00, 8'hFF}, {3'd2, 12'h030, 8'h00, 8'h1E},
    {3'd2, 12'h031, 8'h00, 8'h51}, {3'd2, 12'h032, 8'h00, 8'hFF},
    {3'd2, 12'h033, 8'h00, 8'hFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int w0, e0;
    repeat (3) @(negedge clk);
    chk("R1 ready", ready, 1); chk("R1 dout", dout, 8'hFF);
    chk("R1 we", arr_we, 0);   chk("R1 erase", arr_erase, 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      if (VEC[i][30:28] == 3'd0) begin
        w0 = we_cnt;
        pulse(M_WR, VEC[i][27:16], VEC[i][15:8]);
        chk("R2 busy", ready, 0);
        repeat (W - 1) @(negedge clk);
        chk("R2 still busy", ready, 0);
        @(negedge clk);
        chk("R2 ready again", ready, 1);
        chk("R2 one strobe", we_cnt - w0, 1);
      end else begin
        rd(VEC[i][30:28] == 3'd1 ? M_VER : M_SIG, VEC[i][27:16], v);
        chk(VEC[i][30:28] == 3'd1 ? "R6 verify" : "R11 signature", v, VEC[i][7:0]);
      end
    end

    rd(M_NONE, 12'h005, v); chk("R12 idle mode FF", v, 8'hFF);

    pulse(M_WR, 12'h200, 8'h80);
    mode = M_VER; addr = 12'h200;
    @(negedge clk); chk("R3 polling bit7", dout[7], 1'b0);
    repeat (W) @(negedge clk);
    rd(M_VER, 12'h200, v); chk("R3 true data", v, 8'h80);

    pulse(M_WR, 12'h300, 8'h55);
    pulse(M_WR, 12'h301, 8'h00);
    repeat (W) @(negedge clk);
    rd(M_VER, 12'h301, v); chk("R7 ignored while busy", v, 8'hFF);
    rd(M_VER, 12'h300, v); chk("R7 first write", v, 8'h55);

    hv_ok = 1'b0;
    pulse(M_WR, 12'h302, 8'h00);
    chk("R8 no busy", ready, 1);
    hv_ok = 1'b1;
    rd(M_VER, 12'h302, v); chk("R8 no write", v, 8'hFF);

    e0 = er_cnt;
    hold_erase(10);
    chk("R5 no erase strobe", er_cnt - e0, 0);
    rd(M_VER, 12'h005, v); chk("R5 contents kept", v, 8'h24);

    pulse(M_LK1, 12'h000, 8'h00);
    repeat (W) @(negedge clk);
    rd(M_VER, 12'h005, v); chk("R10 locked read", v, 8'hFF);
    pulse(M_WR, 12'h400, 8'h00);
    chk("R9 write ignored", ready, 1);

    e0 = er_cnt;
    hold_erase(H + 2);
    chk("R4 one erase", er_cnt - e0, 1);
    rd(M_VER, 12'h005, v); chk("R4 erased", v, 8'hFF);
    rd(M_VER, 12'h200, v); chk("R4 erased 2", v, 8'hFF);
    pulse(M_WR, 12'h400, 8'h12);
    repeat (W) @(negedge clk);
    rd(M_VER, 12'h400, v); chk("R4 locks cleared", v, 8'h12);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule